// File: doc/BRIEF.md
# Character CRT Timing and Address Generator

This block times a character-cell raster display. A character clock drives a horizontal character counter. The vertical position is kept as two counters: a scan line within the current character row, and the character row itself. From these counters the block produces display enable, horizontal sync and vertical sync. It also produces a 14-bit linear memory address and the scan-line number that a character generator needs.

The memory address never stops counting. It steps on every character clock, so it runs through both horizontal and vertical blanking and can also be used as a DRAM refresh address. At the end of each line it goes back to the first address of the current character row. When a character row has been fully scanned, the row-start address moves forward by the horizontal displayed count. At the end of each frame it reloads from a programmable start address, which allows hardware scrolling and page flipping without tearing.

A host writes the timing values through a simple select/data port. Every count register holds the wanted count minus one.

Top module: `crt_timing_gen`

## Requirements
- R1: The horizontal counter steps once per clock. It returns to 0 on the clock after it equals the horizontal total register, so a line lasts (htotal+1) clocks. Scan-line and row counters reset only on exact equality with their registers.
- R2: `disp_en` is high exactly when the horizontal counter is below horizontal displayed and the character row is below vertical displayed.
- R3: Within a line, `mem_addr` rises by 1 on every clock, modulo 2^14, including every blanking and sync clock.
- R4: On the first clock of a line that is not the first scan line of a row, `mem_addr` equals the start address of the current row, and `row_addr` is one more than on the previous line.
- R5: After the line whose scan line equals max scan line, `row_addr` returns to 0 and the row-start address grows by horizontal displayed (modulo 2^14).
- R6: After the last scan line of the row equal to vertical total, both the row and the scan line return to 0. `mem_addr` then reloads from the start address register.
- R7: `hsync` is high for hsync-width clocks, starting in the clock where the horizontal counter equals the hsync position. It continues across a line end if the count wraps. A width of 0 gives no pulse.
- R8: `vsync` is high for 16 consecutive lines, starting at scan line 0 of the row equal to the vsync position. It may continue into the next frame.
- R9: A start address written during a frame has no effect on `mem_addr` until the next frame reload.
- R10: Register select codes are: 0 horizontal total, 1 horizontal displayed, 2 hsync position, 3 hsync width (4 bits), 4 vertical total, 5 vertical displayed, 6 vsync position, 7 max scan line (5 bits), 8 start address (14 bits). Each takes the low bits of `cfg_wdata` on the clock after `cfg_we`.
- R11: During reset, all counters are 0, the registers take their parameter defaults, and `mem_addr` equals the default start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select code |
| cfg_wdata | input | 14 | Register write data |
| mem_addr | output | 14 | Linear refresh/display memory address |
| row_addr | output | 5 | Scan line within the character row |
| disp_en | output | 1 | Active display area |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |

## Verification
The bench uses a start address close to the top of the 14-bit space, so a design that fails to wrap the address gives the wrong values partway through the frame. It uses an hsync window that straddles the line end and a vsync run that crosses into the next frame. A design that clears its sync counters at line or frame boundaries cuts those pulses short. A start address written in mid-frame must first appear at the following frame. A design that loads it at once, or on a row advance, shows the new address too early. Every address, enable and sync output is compared on every clock over four frames, so an address that freezes in blanking, or a row advance off by one line, shows up straight away.

// File: rtl/crtg_pkg.sv
package crtg_pkg;
  parameter int HCW     = 8;   // horizontal counter width
  parameter int VRW     = 7;   // character row counter width
  parameter int SLW     = 5;   // scan line counter width
  parameter int MAW     = 14;  // memory address width
  parameter int HSWW    = 4;   // hsync width field
  parameter int VS_LINES = 16; // vsync length in scan lines
  localparam int VSCW   = $clog2(VS_LINES + 1);

  typedef enum logic [3:0] {
    SEL_HTOTAL = 4'd0,
    SEL_HDISP  = 4'd1,
    SEL_HSPOS  = 4'd2,
    SEL_HSWID  = 4'd3,
    SEL_VTOTAL = 4'd4,
    SEL_VDISP  = 4'd5,
    SEL_VSPOS  = 4'd6,
    SEL_MAXSL  = 4'd7,
    SEL_START  = 4'd8
  } cfg_sel_e;

  // next value of a counter that clears on exact match with its limit
  function automatic logic [HCW-1:0] hc_next(input logic [HCW-1:0] cnt,
                                             input logic [HCW-1:0] lim);
    return (cnt == lim) ? '0 : cnt + 1'b1;
  endfunction

  // row start advanced by one character row
  function automatic logic [MAW-1:0] row_advance(input logic [MAW-1:0] base,
                                                 input logic [HCW-1:0] disp);
    return base + MAW'(disp);
  endfunction
endpackage

// File: rtl/crtg_regs.sv
module crtg_regs
  import crtg_pkg::*;
#(
  parameter logic [HCW-1:0]  DEF_HTOTAL = 8'd63,
  parameter logic [HCW-1:0]  DEF_HDISP  = 8'd40,
  parameter logic [HCW-1:0]  DEF_HSPOS  = 8'd46,
  parameter logic [HSWW-1:0] DEF_HSWID  = 4'd14,
  parameter logic [VRW-1:0]  DEF_VTOTAL = 7'd38,
  parameter logic [VRW-1:0]  DEF_VDISP  = 7'd25,
  parameter logic [VRW-1:0]  DEF_VSPOS  = 7'd30,
  parameter logic [SLW-1:0]  DEF_MAXSL  = 5'd7,
  parameter logic [MAW-1:0]  DEF_START  = 14'h0000
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [3:0]      sel,
  input  logic [MAW-1:0]  wdata,
  output logic [HCW-1:0]  htotal,
  output logic [HCW-1:0]  hdisp,
  output logic [HCW-1:0]  hs_pos,
  output logic [HSWW-1:0] hs_wid,
  output logic [VRW-1:0]  vtotal,
  output logic [VRW-1:0]  vdisp,
  output logic [VRW-1:0]  vs_pos,
  output logic [SLW-1:0]  max_sl,
  output logic [MAW-1:0]  start_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      htotal     <= DEF_HTOTAL;
      hdisp      <= DEF_HDISP;
      hs_pos     <= DEF_HSPOS;
      hs_wid     <= DEF_HSWID;
      vtotal     <= DEF_VTOTAL;
      vdisp      <= DEF_VDISP;
      vs_pos     <= DEF_VSPOS;
      max_sl     <= DEF_MAXSL;
      start_addr <= DEF_START;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_HTOTAL: htotal     <= wdata[HCW-1:0];
        SEL_HDISP:  hdisp      <= wdata[HCW-1:0];
        SEL_HSPOS:  hs_pos     <= wdata[HCW-1:0];
        SEL_HSWID:  hs_wid     <= wdata[HSWW-1:0];
        SEL_VTOTAL: vtotal     <= wdata[VRW-1:0];
        SEL_VDISP:  vdisp      <= wdata[VRW-1:0];
        SEL_VSPOS:  vs_pos     <= wdata[VRW-1:0];
        SEL_MAXSL:  max_sl     <= wdata[SLW-1:0];
        SEL_START:  start_addr <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/crtg_hcount.sv
module crtg_hcount
  import crtg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [HCW-1:0]  htotal,
  input  logic [HCW-1:0]  hdisp,
  input  logic [HCW-1:0]  hs_pos,
  input  logic [HSWW-1:0] hs_wid,
  output logic [HCW-1:0]  hc,
  output logic            line_end,
  output logic            hde,
  output logic            hsync
);
  logic [HSWW-1:0] hs_left;
  logic            hs_match;

  assign line_end = (hc == htotal);
  assign hde      = (hc < hdisp);
  assign hs_match = (hc == hs_pos) && (hs_wid != '0);
  assign hsync    = hs_match || (hs_left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hc      <= '0;
      hs_left <= '0;
    end else begin
      hc <= hc_next(hc, htotal);
      if (hs_match)             hs_left <= hs_wid - 1'b1;
      else if (hs_left != '0)   hs_left <= hs_left - 1'b1;
    end
  end

  // R1
  hc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (hc == '0));
  // R7
  hsync_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> (hc == hs_pos));
endmodule

// File: rtl/crtg_vcount.sv
module crtg_vcount
  import crtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           line_end,
  input  logic [VRW-1:0] vtotal,
  input  logic [VRW-1:0] vdisp,
  input  logic [VRW-1:0] vs_pos,
  input  logic [SLW-1:0] max_sl,
  output logic [SLW-1:0] sl,
  output logic           row_end,
  output logic           frame_end,
  output logic           vde,
  output logic           vsync
);
  logic [VRW-1:0]  row;
  logic [VRW-1:0]  row_nxt;
  logic [VSCW-1:0] vs_left;
  logic            vs_start;

  assign row_end   = line_end && (sl == max_sl);
  assign frame_end = row_end && (row == vtotal);
  assign row_nxt   = (row == vtotal) ? '0 : row + 1'b1;
  assign vs_start  = row_end && (row_nxt == vs_pos);
  assign vde       = (row < vdisp);
  assign vsync     = (vs_left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sl      <= '0;
      row     <= '0;
      vs_left <= '0;
    end else begin
      if (line_end) sl <= row_end ? '0 : sl + 1'b1;
      if (row_end)  row <= row_nxt;
      if (vs_start)                    vs_left <= VSCW'(VS_LINES);
      else if (line_end && vsync)      vs_left <= vs_left - 1'b1;
    end
  end

  // R5
  sl_clear_chk: assert property (@(posedge clk) disable iff (rst)
    row_end |=> (sl == '0));
  // R6
  frame_row_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (row == '0));
  // R8
  vsync_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> (sl == '0) && (row == vs_pos));
endmodule

// File: rtl/crtg_addr.sv
module crtg_addr
  import crtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           line_end,
  input  logic           row_end,
  input  logic           frame_end,
  input  logic [HCW-1:0] hdisp,
  input  logic [MAW-1:0] start_addr,
  output logic [MAW-1:0] ma
);
  logic [MAW-1:0] row_start;
  logic [MAW-1:0] next_row;

  assign next_row = row_advance(row_start, hdisp);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_start <= start_addr;
      ma        <= start_addr;
    end else if (frame_end) begin
      row_start <= start_addr;
      ma        <= start_addr;
    end else if (row_end) begin
      row_start <= next_row;
      ma        <= next_row;
    end else if (line_end) begin
      ma        <= row_start;
    end else begin
      ma        <= ma + 1'b1;
    end
  end

  // R3
  ma_run_chk: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> (ma == MAW'($past(ma) + 1'b1)));
  // R4
  ma_return_chk: assert property (@(posedge clk) disable iff (rst)
    (line_end && !row_end) |=> (ma == $past(row_start)));
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
  import crtg_pkg::*;
#(
  parameter logic [HCW-1:0]  DEF_HTOTAL = 8'd63,
  parameter logic [HCW-1:0]  DEF_HDISP  = 8'd40,
  parameter logic [HCW-1:0]  DEF_HSPOS  = 8'd46,
  parameter logic [HSWW-1:0] DEF_HSWID  = 4'd14,
  parameter logic [VRW-1:0]  DEF_VTOTAL = 7'd38,
  parameter logic [VRW-1:0]  DEF_VDISP  = 7'd25,
  parameter logic [VRW-1:0]  DEF_VSPOS  = 7'd30,
  parameter logic [SLW-1:0]  DEF_MAXSL  = 5'd7,
  parameter logic [MAW-1:0]  DEF_START  = 14'h0000
)(
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [3:0]     cfg_sel,
  input  logic [13:0]    cfg_wdata,
  output logic [13:0]    mem_addr,
  output logic [4:0]     row_addr,
  output logic           disp_en,
  output logic           hsync,
  output logic           vsync
);
  logic [HCW-1:0]  htotal, hdisp, hs_pos, hc;
  logic [HSWW-1:0] hs_wid;
  logic [VRW-1:0]  vtotal, vdisp, vs_pos;
  logic [SLW-1:0]  max_sl, sl;
  logic [MAW-1:0]  start_addr, ma;
  logic            line_end, row_end, frame_end, hde, vde;

  crtg_regs #(
    .DEF_HTOTAL(DEF_HTOTAL), .DEF_HDISP(DEF_HDISP), .DEF_HSPOS(DEF_HSPOS),
    .DEF_HSWID(DEF_HSWID), .DEF_VTOTAL(DEF_VTOTAL), .DEF_VDISP(DEF_VDISP),
    .DEF_VSPOS(DEF_VSPOS), .DEF_MAXSL(DEF_MAXSL), .DEF_START(DEF_START)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .htotal(htotal), .hdisp(hdisp), .hs_pos(hs_pos), .hs_wid(hs_wid),
    .vtotal(vtotal), .vdisp(vdisp), .vs_pos(vs_pos), .max_sl(max_sl),
    .start_addr(start_addr)
  );

  crtg_hcount u_h (
    .clk(clk), .rst(rst), .htotal(htotal), .hdisp(hdisp), .hs_pos(hs_pos),
    .hs_wid(hs_wid), .hc(hc), .line_end(line_end), .hde(hde), .hsync(hsync)
  );

  crtg_vcount u_v (
    .clk(clk), .rst(rst), .line_end(line_end), .vtotal(vtotal),
    .vdisp(vdisp), .vs_pos(vs_pos), .max_sl(max_sl), .sl(sl),
    .row_end(row_end), .frame_end(frame_end), .vde(vde), .vsync(vsync)
  );

  crtg_addr u_a (
    .clk(clk), .rst(rst), .line_end(line_end), .row_end(row_end),
    .frame_end(frame_end), .hdisp(hdisp), .start_addr(start_addr), .ma(ma)
  );

  assign mem_addr = ma;
  assign row_addr = sl;
  assign disp_en  = hde && vde;

  // R2
  de_area_chk: assert property (@(posedge clk) disable iff (rst)
    disp_en |-> (hc < hdisp));
endmodule

// File: tb/crt_timing_gen_test.sv
module crt_timing_gen_test;
  localparam int L = 10, S = 4, R = 6, HD = 6, VD = 4, HP = 7, VP = 3;
  localparam int FR = L * S * R;
  localparam int START0 = 'h3FF8, START1 = 'h0100;
  localparam int T_WS = 290, T_WH = 722, T_END = 4 * FR;

  logic clk = 0, rst = 1, cfg_we = 0;
  logic [3:0] cfg_sel = 0;
  logic [13:0] cfg_wdata = 0;
  logic [13:0] mem_addr;
  logic [4:0] row_addr;
  logic disp_en, hsync, vsync;
  int checks = 0, errors = 0;
  bit done = 0;

  crt_timing_gen #(
    .DEF_HTOTAL(8'd9), .DEF_HDISP(8'd6), .DEF_HSPOS(8'd7), .DEF_HSWID(4'd4),
    .DEF_VTOTAL(7'd5), .DEF_VDISP(7'd4), .DEF_VSPOS(7'd3), .DEF_MAXSL(5'd3),
    .DEF_START(14'h3FF8)
  ) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mem_addr(mem_addr), .row_addr(row_addr),
    .disp_en(disp_en), .hsync(hsync), .vsync(vsync)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp, input int t);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", req, t, act, exp);
    end
  endtask

  task automatic check_at(input int t);
    int line, h, fl, row, sl, st, w, ema;
    string tag;
    line = t / L; h = t % L; fl = line % (S * R);
    row = fl / S; sl = fl % S;
    st = (line / (S * R) >= 2) ? START1 : START0;
    w  = (t > T_WH) ? 2 : 4;
    ema = (st + row * HD + h) & 'h3FFF;
    if (h != 0)           tag = "R3";
    else if (fl == 0)     tag = (line >= 2 * S * R) ? "R9" : "R6";
    else if (sl == 0)     tag = "R5";
    else                  tag = "R4";
    chk(tag, mem_addr, ema, t);
    chk("R1", row_addr, sl, t);
    chk("R2", disp_en, (h < HD && row < VD), t);
    chk((t > T_WH) ? "R10" : "R7", hsync, (((h - HP + L) % L) < w), t);
    chk("R8", vsync, (line >= VP * S) && (((fl - VP * S + S * R) % (S * R)) < 16), t);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R11 reset state
    chk("R11", mem_addr, START0, 0);
    chk("R11", row_addr, 0, 0);
    chk("R11", disp_en, 1, 0);
    chk("R11", hsync, 0, 0);
    chk("R11", vsync, 0, 0);
    for (int t = 1; t <= T_END; t++) begin
      @(negedge clk);
      #1;
      check_at(t);
      cfg_we = 0;
      if (t == T_WS) begin  // R9: new start written mid-frame 1
        cfg_we = 1; cfg_sel = 4'd8; cfg_wdata = 14'(START1);
      end
      if (t == T_WH) begin  // R10: hsync width via select 3
        cfg_we = 1; cfg_sel = 4'd3; cfg_wdata = 14'd2;
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule